// File: doc/BRIEF.md
# Chainable serial configuration bit reader

This block is the read side of a one-bit-wide configuration store that feeds a programmable logic device booting in master serial mode. The store is an array of single-bit words, filled with a fixed computed pattern when the design is elaborated. An internal address counter selects the current bit, and that bit appears on the data output with no register in between. Each rising clock edge moves the counter to the next bit while the device is selected and running, so the consumer takes one bit per clock.

Several instances can be chained to form a longer stream. The chip-enable-out of one instance drives the chip-enable input of the next. When an instance has presented its last bit, it stops driving data and pulls its chip-enable-out low. The next instance then wakes up and starts at its own address zero.

A single pin serves as both reset and output enable. A configuration input chooses which level of that pin means reset. A serial-enable pin, when held low, puts the block into programming mode, and normal read-out stops. Inside a larger chip the tri-state is carried as a separate enable output beside the data bit, and the pad ring builds the actual high-impedance buffer from the two.

Top module: `cfg_stream_reader`

## Requirements
- R1: The bit stored at address a equals bit 1 of (a*5) XOR bit 3 of a, for every address 0 to DEPTH-1.
- R2: While the output is enabled, dataOut shows the bit at the current address combinationally, in the same cycle the address is reached.
- R3: The address rises by exactly one on each rising edge where ceN is low, the reset function is inactive, serEn is high and the terminal step has not yet occurred.
- R4: On the edge that leaves address DEPTH-1 while running, ceoN goes low and dataEn goes low. Both stay that way, and the address holds, until a reset.
- R5: ceoN is high from a reset until the terminal step, and any reset returns it high.
- R6: With rstPolHigh=1 the reset level of rstOe is high; with rstPolHigh=0 it is low. An edge seen at the reset level returns the address to 0, and the output is disabled while that level is present. The other level enables the output.
- R7: While ceN is high (standby), dataEn is low and the address does not move.
- R8: While serEn is low (programming mode), dataEn is low and the address does not move.
- R9: A second instance whose ceN is driven by the first instance's ceoN presents its address-0 bit in the cycle right after the first instance's terminal step, then advances one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the consuming device |
| ceN | input | 1 | Chip enable, active low; high selects standby |
| rstOe | input | 1 | Combined reset / output-enable pin |
| rstPolHigh | input | 1 | 1: rstOe high means reset; 0: rstOe low means reset |
| serEn | input | 1 | Serial enable; low selects programming mode |
| dataOut | output | 1 | Bit at the current address |
| dataEn | output | 1 | Drive enable for dataOut; low stands for high impedance |
| ceoN | output | 1 | Chip-enable-out to the next chained instance, low after the last bit |

## Verification
The counter and the terminal flag are registered, while the enable and the data bit are combinational from the pins and that state. A change of ceN, serEn or rstOe therefore shows on dataEn in the same cycle. An address step, a reset clear or a handoff on ceoN shows only after the next rising edge. The bench changes the inputs two time units after an edge, waits for the following edge, and samples two units later. The one exception is the release of reset, where it samples one unit after the input change to see the combinational address-0 bit before any edge. In the chained case, the second instance is checked in the cycle right after the edge that raises the first instance's terminal flag.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef struct packed {
    logic clear;
    logic advance;
  } strobe_t;

  function automatic logic pattern_bit(input int unsigned a);
    int unsigned p;
    p = a * 5;
    return p[1] ^ a[3];
  endfunction

endpackage

// File: rtl/cfg_stream_dpath.sv
module cfg_stream_dpath
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic    clk,
  input  strobe_t strb,
  output logic    bitVal,
  output logic    atLast
);

  logic [DEPTH-1:0] memBits;
  logic [AW-1:0]    addr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign memBits[i] = pattern_bit(i);
  end

  always_ff @(posedge clk) begin
    if (strb.clear)        addr <= '0;
    else if (strb.advance) addr <= addr + AW'(1);
  end

  assign bitVal = memBits[addr];
  assign atLast = (addr == AW'(DEPTH - 1));

  p_step_r3: assert property (@(posedge clk) disable iff (strb.clear)
    strb.advance |=> addr == $past(addr) + AW'(1));

  p_hold_r7: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.advance |=> $stable(addr));

  p_clear_r6: assert property (@(posedge clk)
    strb.clear |=> addr == '0);

  p_range_r4: assert property (@(posedge clk) disable iff (strb.clear)
    addr <= AW'(DEPTH - 1));

endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
(
  input  logic    clk,
  input  logic    ceN,
  input  logic    rstOe,
  input  logic    rstPolHigh,
  input  logic    serEn,
  input  logic    atLast,
  output strobe_t strb,
  output logic    drive,
  output logic    ceoN
);

  logic rstAct;
  logic running;
  logic done;

  assign rstAct  = rstPolHigh ? rstOe : ~rstOe;
  assign running = ~ceN & serEn & ~rstAct;

  always_ff @(posedge clk) begin
    if (rstAct)                        done <= 1'b0;
    else if (running && atLast && !done) done <= 1'b1;
  end

  always_comb begin
    strb.clear   = rstAct;
    strb.advance = running & ~done & ~atLast;
  end

  assign drive = running & ~done;
  assign ceoN  = ~done;

  p_handoff_r4: assert property (@(posedge clk) disable iff (rstAct)
    (running && atLast && !done) |=> done);

  p_done_sticks_r4: assert property (@(posedge clk) disable iff (rstAct)
    done |=> done);

  p_ceo_back_r5: assert property (@(posedge clk)
    rstAct |=> ceoN);

  p_standby_quiet_r7: assert property (@(posedge clk)
    ceN |-> !drive);

  p_prog_quiet_r8: assert property (@(posedge clk)
    !serEn |-> !drive);

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic ceN,
  input  logic rstOe,
  input  logic rstPolHigh,
  input  logic serEn,
  output logic dataOut,
  output logic dataEn,
  output logic ceoN
);

  strobe_t strb;
  logic    atLast;
  logic    bitVal;
  logic    drive;

  cfg_stream_ctrl u_ctrl (
    .clk        (clk),
    .ceN        (ceN),
    .rstOe      (rstOe),
    .rstPolHigh (rstPolHigh),
    .serEn      (serEn),
    .atLast     (atLast),
    .strb       (strb),
    .drive      (drive),
    .ceoN       (ceoN)
  );

  cfg_stream_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk    (clk),
    .strb   (strb),
    .bitVal (bitVal),
    .atLast (atLast)
  );

  assign dataOut = bitVal;
  assign dataEn  = drive;

endmodule

// File: tb/cfg_stream_reader_bench.sv
module cfg_stream_reader_bench;

  localparam int DEPTH = 16;

  typedef struct packed {
    logic       ceN;
    logic       rstOn;
    logic       serEn;
    logic       expEn;
    logic [4:0] expAddr;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 5'd0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd1},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd2},
    '{1'b1, 1'b0, 1'b1, 1'b0, 5'd2},
    '{1'b1, 1'b0, 1'b1, 1'b0, 5'd2},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd3},
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd3},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd4},
    '{1'b0, 1'b1, 1'b1, 1'b0, 5'd0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd1},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd2},
    '{1'b1, 1'b0, 1'b0, 1'b0, 5'd2},
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd3}
  };

  logic clk = 1'b0;
  logic ceN = 1'b0;
  logic rstOe = 1'b1;
  logic rstPolHigh = 1'b1;
  logic serEn = 1'b1;
  logic dataOut, dataEn, ceoN;
  logic dataOut2, dataEn2, ceoN2;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_stream_reader #(.DEPTH(DEPTH)) u_cfg_stream_reader (
    .clk(clk), .ceN(ceN), .rstOe(rstOe), .rstPolHigh(rstPolHigh), .serEn(serEn),
    .dataOut(dataOut), .dataEn(dataEn), .ceoN(ceoN)
  );

  cfg_stream_reader #(.DEPTH(DEPTH)) u_next (
    .clk(clk), .ceN(ceoN), .rstOe(rstOe), .rstPolHigh(rstPolHigh), .serEn(serEn),
    .dataOut(dataOut2), .dataEn(dataEn2), .ceoN(ceoN2)
  );

  function automatic logic refBit(input int a);
    return logic'(((a * 5) >> 1) & 1) ^ logic'((a >> 3) & 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic setRst(input bit on);
    rstOe = rstPolHigh ? on : ~on;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state, R5 and R6
    setRst(1'b1);
    step();
    step();
    chk(ceoN == 1'b1, "R5 ceoN at reset", ceoN, 1);
    chk(dataEn == 1'b0, "R6 output off in reset", dataEn, 0);

    // vector table: R2 R3 R6 R7 R8
    for (int i = 0; i < 13; i++) begin
      ceN = VEC[i].ceN;
      setRst(VEC[i].rstOn);
      serEn = VEC[i].serEn;
      step();
      chk(dataEn == VEC[i].expEn, $sformatf("R3/R7/R8 vector %0d enable", i), dataEn, VEC[i].expEn);
      chk(ceoN == 1'b1, $sformatf("R5 vector %0d ceoN", i), ceoN, 1);
      if (VEC[i].expEn)
        chk(dataOut == refBit(int'(VEC[i].expAddr)), $sformatf("R2 vector %0d data", i),
            dataOut, refBit(int'(VEC[i].expAddr)));
    end

    // full stream, terminal step and cascade: R1 R4 R9
    ceN = 1'b0;
    serEn = 1'b1;
    setRst(1'b1);
    step();
    setRst(1'b0);
    #1;
    chk(dataEn == 1'b1 && dataOut == refBit(0), "R2 address 0 before edge", dataOut, refBit(0));
    for (int k = 1; k < DEPTH; k++) begin
      step();
      chk(dataEn == 1'b1 && dataOut == refBit(k), $sformatf("R1 bit %0d", k), dataOut, refBit(k));
      chk(dataEn2 == 1'b0, "R7 downstream in standby", dataEn2, 0);
    end
    step();
    chk(ceoN == 1'b0, "R4 ceoN low at terminal", ceoN, 0);
    chk(dataEn == 1'b0, "R4 output off at terminal", dataEn, 0);
    chk(dataEn2 == 1'b1 && dataOut2 == refBit(0), "R9 downstream address 0", dataOut2, refBit(0));
    for (int k = 1; k < DEPTH; k++) begin
      step();
      chk(dataEn2 == 1'b1 && dataOut2 == refBit(k), $sformatf("R9 downstream bit %0d", k), dataOut2, refBit(k));
      chk(ceoN == 1'b0 && dataEn == 1'b0, "R4 upstream stays finished", dataEn, 0);
    end
    chk(ceoN2 == 1'b1, "R5 downstream ceoN before its end", ceoN2, 1);
    step();
    chk(ceoN2 == 1'b0, "R4 downstream terminal", ceoN2, 0);

    // reset restores ceoN: R5
    setRst(1'b1);
    step();
    chk(ceoN == 1'b1 && ceoN2 == 1'b1, "R5 ceoN restored by reset", ceoN, 1);

    // low polarity: R6
    rstPolHigh = 1'b0;
    rstOe = 1'b1;
    step();
    chk(dataEn == 1'b1, "R6 high level not reset when pol low", dataEn, 1);
    rstOe = 1'b0;
    step();
    chk(dataEn == 1'b0, "R6 low level is reset when pol low", dataEn, 0);
    rstOe = 1'b1;
    #1;
    chk(dataEn == 1'b1 && dataOut == refBit(0), "R6 cleared to address 0", dataOut, refBit(0));
    step();
    chk(dataOut == refBit(1), "R3 advance after low-pol release", dataOut, refBit(1));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule